// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous page-mode DRAM alive. After reset it waits out the power-up pause. It then runs a burst of warm-up refresh cycles and only after that raises `init_done`, which tells the access controller it may start taking host requests. During normal operation an interval timer adds one owed refresh at a fixed spacing, so that every row is refreshed inside the retention window: 1024 rows in 16 ms, which is one refresh about every 15.6 µs.

Refreshes use the CAS-before-RAS form, so the device supplies the row address itself and the sequencer drives no address. The block raises `ref_req` toward the open-page access controller. That controller closes its open row and answers with `ref_gnt`. While the grant is held, the sequencer drives CAS#, then RAS#, then a full precharge. Refreshes that are owed but not yet granted are counted, up to a saturating limit. Once the count reaches a threshold, `ref_urgent` tells the controller to stop extending page hits. All intervals are given in nanoseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `ref_req` and `init_done` stay low for at least the power-up pause of PAUSE_NS converted to cycles (200 µs by default).
- R2: After the pause, exactly WARMUP (8) refresh cycles run. `init_done` rises only after the last of them and then stays high until the next reset.
- R3: In every refresh, CAS# falls while RAS# is high. RAS# falls after CAS# has been low for at least the setup time. CAS# stays low for at least the hold time after RAS# falls, and is back high before RAS# rises.
- R4: RAS# has been high for at least the precharge time when CAS# falls. RAS# stays low for at least the larger of the RAS pulse width and (cycle time − precharge); with the default timing at a 50 MHz clock that is 3 cycles.
- R5: WE# is high at all times.
- R6: RAS# and CAS# are driven low only while `ref_gnt` is high. `ref_req` stays high until the precharge of the refresh has ended.
- R7: Once `init_done` is high, one refresh becomes owed every REFI_NS converted to cycles. Successive refreshes with the grant always given are spaced by exactly that count.
- R8: The owed-refresh count saturates at OWED_MAX (8). Timer ticks that arrive while it is full are dropped, so a backlog never yields more than 8 refreshes.
- R9: `ref_urgent` is high exactly while the owed count is at least URGENT_AT (4): a backlog of 3 gives low, a backlog of 4 gives high.
- R10: While the grant is held, owed refreshes run back to back until the count is zero, and then `ref_req` falls.
- R11: While `rst_n` is low, RAS#, CAS# and WE# are high and `ref_req`, `ref_urgent` and `init_done` are low. This holds at once, even in the middle of a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller grants the DRAM pins (open row closed) |
| ref_req | output | 1 | A refresh is owed or in progress |
| ref_urgent | output | 1 | Owed count at or above threshold; stop page hits |
| init_done | output | 1 | Warm-up finished; normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
Latencies through the block are as follows:
- An interval tick updates the owed count at the next edge, so `ref_req` and `ref_urgent` follow one cycle after the tick.
- In the bench, the grant is a register fed by `ref_req`, and CAS# falls only after the precharge phase, which starts one edge after the grant is seen.
- Each refresh then takes precharge + setup + RAS-low + precharge cycles plus one idle cycle.

All outputs are sampled on the falling clock edge. Checks on waiting intervals are bounded windows around the pause and tick times rather than single cycles. The bench withholds the grant until the backlog has settled 20 cycles after the last tick and checks the urgency level there. It then counts RAS# falls until `ref_req` drops, which happens well before the next tick is due.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CSR,
    ST_RAS,
    ST_RP
  } ref_state_t;

  // Round a duration up to whole clock cycles, never fewer than one.
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned LIMIT   = 1560,
  parameter bit          ONESHOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  generate
    if (ONESHOT) begin : g_oneshot
      // Counts up to LIMIT once and holds; hit is a level.
      always_comb begin
        cnt_d = cnt_q;
        if (en && (cnt_q != LIM_V)) cnt_d = cnt_q + 1'b1;
      end
      assign hit = (cnt_q == LIM_V);
    end else begin : g_periodic
      // Wraps every LIMIT enabled cycles; hit is a one-cycle pulse.
      logic last;
      assign last = (cnt_q == LAST_V);
      always_comb begin
        cnt_d = '0;
        if (en) cnt_d = last ? '0 : cnt_q + 1'b1;
      end
      assign hit = en && last;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dram_ref_owed.sv
module dram_ref_owed #(
  parameter int unsigned WARMUP    = 8,
  parameter int unsigned OWED_MAX  = 8,
  parameter int unsigned URGENT_AT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic cycle_done,
  output logic owed_any,
  output logic urgent,
  output logic init_done
);
  localparam int unsigned WW = $clog2(WARMUP + 1);
  localparam int unsigned PW = $clog2(OWED_MAX + 1);
  localparam logic [WW-1:0] WARM_V = WW'(WARMUP);
  localparam logic [PW-1:0] MAX_V  = PW'(OWED_MAX);
  localparam logic [PW-1:0] URG_V  = PW'(URGENT_AT);

  logic [WW-1:0] warm_q, warm_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          init_q, init_d;
  logic          warm_zero, inc, dec;

  assign warm_zero = (warm_q == '0);
  assign inc       = tick && (pend_q != MAX_V);
  assign dec       = cycle_done && warm_zero && (pend_q != '0);

  always_comb begin
    warm_d = warm_q;
    if (cycle_done && !warm_zero) warm_d = warm_q - 1'b1;

    pend_d = pend_q;
    if (inc && !dec)      pend_d = pend_q + 1'b1;
    else if (dec && !inc) pend_d = pend_q - 1'b1;

    init_d = init_q || (pause_done && warm_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= WARM_V;
      pend_q <= '0;
      init_q <= 1'b0;
    end else begin
      warm_q <= warm_d;
      pend_q <= pend_d;
      init_q <= init_d;
    end
  end

  assign owed_any  = (pend_q != '0) || (pause_done && !warm_zero);
  assign urgent    = (pend_q >= URG_V);
  assign init_done = init_q;

endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned PRE_C = 3,
  parameter int unsigned CSR_C = 1,
  parameter int unsigned RAS_C = 6,
  parameter int unsigned CHR_C = 1,
  parameter int unsigned RP_C  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed_any,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic cycle_done
);
  localparam int unsigned MAXP = umax(umax(PRE_C, CSR_C), umax(umax(RAS_C, CHR_C), RP_C));
  localparam int unsigned PHW  = $clog2(MAXP + 1);

  ref_state_t     st_q, st_d;
  logic [PHW-1:0] cnt_q, cnt_d;
  logic           ras_d, cas_d, ras_q, cas_q;

  function automatic logic at_end(input logic [PHW-1:0] c, input int unsigned len);
    return c == PHW'(len - 1);
  endfunction

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q + 1'b1;
    cycle_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (owed_any && gnt) st_d = ST_PRE;
      end
      ST_PRE: if (at_end(cnt_q, PRE_C)) begin st_d = ST_CSR; cnt_d = '0; end
      ST_CSR: if (at_end(cnt_q, CSR_C)) begin st_d = ST_RAS; cnt_d = '0; end
      ST_RAS: if (at_end(cnt_q, RAS_C)) begin st_d = ST_RP;  cnt_d = '0; end
      ST_RP: begin
        if (at_end(cnt_q, RP_C)) begin
          st_d       = ST_IDLE;
          cnt_d      = '0;
          cycle_done = 1'b1;
        end
      end
      default: begin st_d = ST_IDLE; cnt_d = '0; end
    endcase
    // Pin levels follow the next state so they change on the same edge.
    ras_d = (st_d != ST_RAS);
    cas_d = !((st_d == ST_CSR) || ((st_d == ST_RAS) && (cnt_d < PHW'(CHR_C))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ras_q <= ras_d;
      cas_q <= cas_d;
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign busy  = (st_q != ST_IDLE);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned PAUSE_NS  = 200_000,
  parameter int unsigned REFI_NS   = 15_600,
  parameter int unsigned WARMUP    = 8,
  parameter int unsigned OWED_MAX  = 8,
  parameter int unsigned URGENT_AT = 4,
  parameter int unsigned T_CSR_NS  = 10,
  parameter int unsigned T_CHR_NS  = 10,
  parameter int unsigned T_RAS_NS  = 50,
  parameter int unsigned T_RC_NS   = 90,
  parameter int unsigned T_RP_NS   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_HZ);
  localparam int unsigned REFI_CYC  = ns_to_cyc(REFI_NS, CLK_HZ);
  localparam int unsigned PRE_CYC   = ns_to_cyc(T_RP_NS, CLK_HZ);
  localparam int unsigned CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_HZ);
  localparam int unsigned CHR_CYC   = ns_to_cyc(T_CHR_NS, CLK_HZ);
  localparam int unsigned RAS_CYC   = ns_to_cyc(umax(T_RAS_NS, T_RC_NS - T_RP_NS), CLK_HZ);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_HZ);

  logic [1:0] rst_sync;
  logic       rst_s_n;
  logic       pause_done, tick, owed_any, busy, cycle_done, init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  dram_ref_timer #(.LIMIT(PAUSE_CYC), .ONESHOT(1'b1)) u_pause (
    .clk(clk), .rst_n(rst_s_n), .en(1'b1), .hit(pause_done)
  );

  dram_ref_timer #(.LIMIT(REFI_CYC), .ONESHOT(1'b0)) u_interval (
    .clk(clk), .rst_n(rst_s_n), .en(init_q), .hit(tick)
  );

  dram_ref_owed #(.WARMUP(WARMUP), .OWED_MAX(OWED_MAX), .URGENT_AT(URGENT_AT)) u_owed (
    .clk(clk), .rst_n(rst_s_n), .pause_done(pause_done), .tick(tick),
    .cycle_done(cycle_done), .owed_any(owed_any), .urgent(ref_urgent),
    .init_done(init_q)
  );

  dram_ref_fsm #(.PRE_C(PRE_CYC), .CSR_C(CSR_CYC), .RAS_C(RAS_CYC),
                 .CHR_C(CHR_CYC), .RP_C(RP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .owed_any(owed_any), .gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .cycle_done(cycle_done)
  );

  assign ref_req   = owed_any || busy;
  assign init_done = init_q;
  assign we_n      = 1'b1;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned RAS_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_urgent,
  input logic init_done,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  logic [7:0] ras_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ras_low_cnt <= '0;
    else if (ras_n)            ras_low_cnt <= '0;
    else if (ras_low_cnt != 8'hFF) ras_low_cnt <= ras_low_cnt + 1'b1;
  end

  // R3: CAS# already low before RAS# falls and still low at the fall
  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R3: CAS# released before RAS# returns high
  a_r3_cas_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R4: RAS# low width
  a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_low_cnt >= 8'(RAS_CYC)));

  // R6: pins move only under grant, with the request held
  a_r6_pins_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (ref_gnt && ref_req));

  // R2: init_done is sticky
  a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9: urgency implies an open request
  a_r9_urgent_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  // R5: write enable never active
  a_r5_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    we_n);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.RAS_CYC(RAS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .init_done(init_done), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  // 50 MHz clock, shortened pause and interval to keep the run short.
  localparam int unsigned HZ       = 50_000_000;
  localparam int unsigned PAUSE_NS = 4_000;
  localparam int unsigned REFI_NS  = 3_000;
  localparam int TCK   = 20;
  localparam int PAUSE = PAUSE_NS / TCK;           // 200
  localparam int REFI  = REFI_NS / TCK;            // 150
  localparam int PRE_C = (30 + TCK - 1) / TCK;     // 2
  localparam int CSR_C = (10 + TCK - 1) / TCK;     // 1
  localparam int CHR_C = (10 + TCK - 1) / TCK;     // 1
  localparam int RAS_C = (60 + TCK - 1) / TCK;     // 3: max(50, 90-30)

  // Vector table: grant withheld over N ticks; expected urgency and refresh count.
  localparam int NV = 5;
  localparam int V_HOLD[NV] = '{1, 3, 4, 7, 10};
  localparam int V_URG [NV] = '{0, 0, 1, 1, 1};
  localparam int V_PUL [NV] = '{1, 3, 4, 7, 8};

  logic clk, rst_n, ref_gnt, gnt_en;
  logic ref_req, ref_urgent, init_done, ras_n, cas_n, we_n;

  int nchk = 0, nerr = 0, cyc = 0, pulses = 0;
  logic pr_ras = 1'b1, pr_cas = 1'b1;
  int ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0;

  dram_refresh_seq #(.CLK_HZ(HZ), .PAUSE_NS(PAUSE_NS), .REFI_NS(REFI_NS)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .init_done(init_done), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Access controller model: grants one cycle after the request, when allowed.
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ref_gnt <= 1'b0;
    else        ref_gnt <= gnt_en & ref_req;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Pin-sequence monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pr_ras && !ras_n) begin
        pulses++;
        chk(!pr_cas && !cas_n, "R3 CAS low at RAS fall", cas_n, 0);
        chk(cas_lo_run >= CSR_C, "R3 CAS setup", cas_lo_run, CSR_C);
        chk(we_n, "R5 WE high", we_n, 1);
      end
      if (pr_cas && !cas_n && ras_n)
        chk(ras_hi_run >= PRE_C, "R4 precharge before CAS", ras_hi_run, PRE_C);
      if (!pr_cas && cas_n && !ras_n)
        chk(ras_lo_run >= CHR_C, "R3 CAS hold", ras_lo_run, CHR_C);
      if (!pr_ras && ras_n) begin
        chk(ras_lo_run >= RAS_C, "R4 RAS low width", ras_lo_run, RAS_C);
        chk(cas_n, "R3 CAS released", cas_n, 1);
      end
    end
    ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
    ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
    cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
    pr_ras = ras_n;
    pr_cas = cas_n;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  task automatic wait_req(input logic lvl, output int n);
    n = 0;
    while (ref_req !== lvl && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, p0, t0;
    rst_n = 1'b0; gnt_en = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ras_n && cas_n && we_n, "R11 pins high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !ref_urgent && !init_done, "R11 outputs low in reset",
        {ref_req, ref_urgent, init_done}, 0);

    rst_n = 1'b1;
    // R1: silent through the pause
    repeat (PAUSE - 10) @(negedge clk);
    chk(!ref_req && !init_done, "R1 quiet during pause", {ref_req, init_done}, 0);
    wait_req(1'b1, n);
    n = n + PAUSE - 10;
    chk(n >= PAUSE && n <= PAUSE + 5, "R1 first request after pause", n, PAUSE);
    chk(!init_done, "R2 not done before warm-up", init_done, 0);

    // R2: warm-up burst
    p0 = pulses; n = 0;
    while (!init_done && n < 2000) begin @(negedge clk); n++; end
    chk(pulses - p0 == 8, "R2 warm-up refresh count", pulses - p0, 8);
    chk(init_done, "R2 init_done raised", init_done, 1);
    gnt_en = 1'b0;

    // Vector table walk: R7, R8, R9, R10, R6
    for (int i = 0; i < NV; i++) begin
      gnt_en = 1'b0;
      wait_req(1'b1, n);
      if (i == 0) chk(n >= REFI - 2 && n <= REFI + 2, "R7 first tick spacing", n, REFI);
      repeat ((V_HOLD[i] - 1) * REFI + 20) @(negedge clk);
      chk(ref_urgent == V_URG[i][0], "R9 urgency level", ref_urgent, V_URG[i]);
      chk(ras_n && cas_n && ref_req, "R6 no pins without grant",
          {ras_n, cas_n, ref_req}, 7);
      p0 = pulses;
      gnt_en = 1'b1;
      wait_req(1'b0, n);
      chk(pulses - p0 == V_PUL[i], "R8 R10 backlog refresh count", pulses - p0, V_PUL[i]);
      chk(!ref_urgent, "R9 urgency cleared", ref_urgent, 0);
    end

    // R7: steady spacing with grant always given
    gnt_en = 1'b1;
    p0 = pulses;
    while (pulses == p0) @(negedge clk);
    t0 = cyc; p0 = pulses;
    while (pulses == p0) @(negedge clk);
    chk(cyc - t0 == REFI, "R7 refresh spacing", cyc - t0, REFI);

    // R11: reset in the middle of a refresh
    while (ras_n) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n && we_n, "R11 pins released by reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !init_done && !ref_urgent, "R11 outputs cleared by reset",
        {ref_req, init_done, ref_urgent}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule